// File: doc/BRIEF.md
# TLB-Backed Page Address Translator

This block turns 32-bit virtual addresses into physical addresses for a paged memory system. The page size is 4096 bytes. The upper 20 bits of a virtual address select the virtual page and the low 12 bits locate a byte within it. Translations are first looked up in a small two-way set-associative buffer of recently used mappings. Both ways of the selected set are compared in the same cycle, so a hit is answered on the next clock.

When the page is not in the buffer, the block walks a single-level page table held in main memory. That table has one 32-bit entry for every virtual page, so it holds 2^20 entries. The walk issues one read on a simple request/response port. A valid entry yields the physical address and is written into the buffer. An invalid entry produces a page-fault pulse instead.

A flush input empties the buffer in one cycle, for example after the page table has been rewritten. While a walk is in progress the block is not ready, and any request offered during that time is dropped.

Top module: `tlb_translator`

## Requirements
- R1: After reset, `ready` is 1 and `done`, `fault` and `mem_req_valid` are 0, and the buffer holds no mapping, so the first access to any page starts a table walk.
- R2: A request accepted (with `req_valid` and `ready` both high at a clock edge) whose page is buffered raises `done` in the cycle after acceptance. It issues no memory read. `paddr` is the buffered 20-bit frame in bits 31:12 followed by bits 11:0 of the virtual address, unchanged.
- R3: A request that misses raises `mem_req_valid` for exactly one cycle, starting the cycle after acceptance. `mem_req_addr` is the base sampled at acceptance plus four times the virtual page number.
- R4: A table entry has its valid flag at bit 31 and its frame number at bits 19:0. When the response to a walk carries a set valid flag, `done` rises in the cycle after `mem_rsp_valid` is sampled, with `paddr` built from that frame. The mapping is then buffered, so the next access to the same page hits.
- R5: A response whose bit 31 is clear raises `fault` for one cycle in the cycle after the response, keeps `done` low, and installs nothing, so a repeat access walks again.
- R6: The buffer has 8 sets of 2 ways each. The set is selected by the low 3 bits of the page number, and the remaining 17 bits form the tag. Two pages that share a set are held together.
- R7: Each set keeps one replacement bit. A hit or a refill marks the other way as the next victim, so a third page mapping to a full set evicts the way used least recently.
- R8: `flush` clears every buffered mapping at the next edge. A request accepted in the same cycle as `flush` is treated as a miss. A refill that coincides with `flush` is not written.
- R9: `ready` is low from the cycle after a miss is accepted until the result appears. A request offered while `ready` is low produces no result and no memory read.
- R10: `done` and `fault` are never high together, and a hit's `done` lasts one cycle when no further request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| pt_base | input | 32 | Byte address of the page table, sampled at acceptance |
| flush | input | 1 | Invalidate all buffered mappings |
| ready | output | 1 | Block can accept a request |
| done | output | 1 | One-cycle pulse: `paddr` is valid |
| paddr | output | 32 | Translated physical address |
| fault | output | 1 | One-cycle pulse: the table entry was invalid |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Table entry read from memory |

## Verification
A hit result is due one cycle after the accepting edge, so the bench samples `done` and `paddr` at the next falling edge. It then samples again one cycle later to see the pulse end. On a miss, the bench expects the memory read at the first falling edge after acceptance and expects it gone by the second. The bench's memory model drives the response two cycles later, and the translated address or fault is sampled at the falling edge after the edge that takes the response. Probes for dropped requests and for flush effects are sampled in the cycle immediately after the stimulus, before any other request is offered.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int VA_W        = 32;
    localparam int OFF_W       = 12;
    localparam int VPN_W       = VA_W - OFF_W;
    localparam int PFN_W       = 20;
    localparam int PA_W        = PFN_W + OFF_W;
    localparam int PTE_W       = 32;
    localparam int PTE_VLD_BIT = PTE_W - 1;
    localparam int WAYS        = 2;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_ISSUE,
        WK_WAIT
    } wk_state_e;

    typedef struct packed {
        wk_state_e          st;
        logic [VPN_W-1:0]   vpn;
        logic [OFF_W-1:0]   off;
        logic [VA_W-1:0]    base;
        logic               done;
        logic               fault;
        logic [PA_W-1:0]    pa;
    } wk_regs_t;

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlbx_pkg::*;
#(
    parameter int SETS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              flush,
    input  logic              touch_en,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    output logic              hit,
    output logic [PFN_W-1:0]  hit_pfn
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][PFN_W-1:0]  pfn;
        logic [SETS-1:0]                       victim;
    } store_t;

    store_t st_d, st_q;

    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [WAYS-1:0]  way_hit;
    logic             hit_way;
    logic [IDX_W-1:0] fl_idx;
    logic             fl_way;

    assign lk_idx = lk_vpn[IDX_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
    assign fl_idx = fill_vpn[IDX_W-1:0];
    assign fl_way = st_q.victim[fl_idx];

    // parallel compare of every way in the selected set
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = st_q.vld[lk_idx][w]
                          && (st_q.tag[lk_idx][w] == lk_tag)
                          && !flush;
    end

    assign hit     = |way_hit;
    assign hit_way = way_hit[1];

    always_comb begin
        hit_pfn = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) hit_pfn = hit_pfn | st_q.pfn[lk_idx][w];
        end
    end

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.vld    = '0;
            st_d.victim = '0;
        end else begin
            if (touch_en && hit) begin
                st_d.victim[lk_idx] = ~hit_way;
            end
            if (fill_en) begin
                st_d.vld[fl_idx][fl_way] = 1'b1;
                st_d.tag[fl_idx][fl_way] = fill_vpn[VPN_W-1:IDX_W];
                st_d.pfn[fl_idx][fl_way] = fill_pfn;
                st_d.victim[fl_idx]      = ~fl_way;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
    import tlbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [VA_W-1:0]   pt_base,
    input  logic              lk_hit,
    input  logic [PFN_W-1:0]  lk_pfn,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              touch_en,
    output logic              fill_en,
    output logic [VPN_W-1:0]  fill_vpn,
    output logic [PFN_W-1:0]  fill_pfn,
    output logic              ready,
    output logic              done,
    output logic              fault,
    output logic [PA_W-1:0]   paddr,
    output logic              mem_req_valid,
    output logic [VA_W-1:0]   mem_req_addr
);

    localparam int PAD_W = VA_W - VPN_W - 2;

    wk_regs_t wk_d, wk_q;
    logic     unused_rsp_bits;

    assign unused_rsp_bits = ^mem_rsp_data[PTE_W-2:PFN_W];

    always_comb begin
        wk_d       = wk_q;
        wk_d.done  = 1'b0;
        wk_d.fault = 1'b0;
        touch_en   = 1'b0;
        fill_en    = 1'b0;
        unique case (wk_q.st)
            WK_IDLE: begin
                if (req_valid) begin
                    wk_d.vpn  = req_vaddr[VA_W-1:OFF_W];
                    wk_d.off  = req_vaddr[OFF_W-1:0];
                    wk_d.base = pt_base;
                    if (lk_hit) begin
                        touch_en  = 1'b1;
                        wk_d.done = 1'b1;
                        wk_d.pa   = {lk_pfn, req_vaddr[OFF_W-1:0]};
                    end else begin
                        wk_d.st = WK_ISSUE;
                    end
                end
            end
            WK_ISSUE: begin
                wk_d.st = WK_WAIT;
            end
            WK_WAIT: begin
                if (mem_rsp_valid) begin
                    wk_d.st = WK_IDLE;
                    if (mem_rsp_data[PTE_VLD_BIT]) begin
                        fill_en   = 1'b1;
                        wk_d.done = 1'b1;
                        wk_d.pa   = {mem_rsp_data[PFN_W-1:0], wk_q.off};
                    end else begin
                        wk_d.fault = 1'b1;
                    end
                end
            end
            default: wk_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wk_q <= '{st: WK_IDLE, default: '0};
        else        wk_q <= wk_d;
    end

    assign ready         = (wk_q.st == WK_IDLE);
    assign mem_req_valid = (wk_q.st == WK_ISSUE);
    assign mem_req_addr  = wk_q.base + {{PAD_W{1'b0}}, wk_q.vpn, 2'b00};
    assign fill_vpn      = wk_q.vpn;
    assign fill_pfn      = mem_rsp_data[PFN_W-1:0];
    assign done          = wk_q.done;
    assign fault         = wk_q.fault;
    assign paddr         = wk_q.pa;

endmodule

// File: rtl/tlb_translator.sv
module tlb_translator
    import tlbx_pkg::*;
#(
    parameter int SETS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [VA_W-1:0]   pt_base,
    input  logic              flush,
    output logic              ready,
    output logic              done,
    output logic [PA_W-1:0]   paddr,
    output logic              fault,
    output logic              mem_req_valid,
    output logic [VA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data
);

    logic              lk_hit;
    logic [PFN_W-1:0]  lk_pfn;
    logic              touch_en;
    logic              fill_en;
    logic [VPN_W-1:0]  fill_vpn;
    logic [PFN_W-1:0]  fill_pfn;

    tlb_store #(.SETS(SETS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (req_vaddr[VA_W-1:OFF_W]),
        .flush    (flush),
        .touch_en (touch_en),
        .fill_en  (fill_en),
        .fill_vpn (fill_vpn),
        .fill_pfn (fill_pfn),
        .hit      (lk_hit),
        .hit_pfn  (lk_pfn)
    );

    tlb_walker u_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .pt_base       (pt_base),
        .lk_hit        (lk_hit),
        .lk_pfn        (lk_pfn),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .touch_en      (touch_en),
        .fill_en       (fill_en),
        .fill_vpn      (fill_vpn),
        .fill_pfn      (fill_pfn),
        .ready         (ready),
        .done          (done),
        .fault         (fault),
        .paddr         (paddr),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr)
    );

endmodule

// File: rtl/tlb_translator_chk.sv
module tlb_translator_chk
    import tlbx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              flush,
    input logic              ready,
    input logic              done,
    input logic              fault,
    input logic              mem_req_valid,
    input logic              mem_rsp_valid
);

    // R3: the table read request lasts exactly one cycle
    assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R3: a table read follows directly on an accepted request
    assert_req_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> $past(req_valid && ready));

    // R9: no request can be accepted while a read is outstanding
    assert_busy_on_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !ready);

    // R10: a result is either a translation or a fault
    assert_excl_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R4: every result is caused by an acceptance or a memory response
    assert_result_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> ($past(mem_rsp_valid) || $past(req_valid && ready)));

    // R8: a request taken together with a flush walks the table
    assert_flush_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && req_valid && ready) |=> (mem_req_valid && !done));

    logic unused_chk_addr;
    assign unused_chk_addr = ^req_vaddr;

endmodule

bind tlb_translator tlb_translator_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .flush         (flush),
    .ready         (ready),
    .done          (done),
    .fault         (fault),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/tb_tlb_translator.sv
`timescale 1ns/1ps
module tb_tlb_translator;

    localparam logic [31:0] BASE = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] pt_base = BASE;
    logic        flush = 1'b0;
    logic        ready, done, fault, mem_req_valid;
    logic [31:0] paddr, mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tlb_translator dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .pt_base(pt_base), .flush(flush), .ready(ready), .done(done),
        .paddr(paddr), .fault(fault), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    // memory model: page valid unless vpn[11:8]==F, frame = vpn ^ 3C3C3
    function automatic logic [31:0] pte_of(input logic [19:0] vpn);
        return {(vpn[11:8] != 4'hF), 11'b0, vpn ^ 20'h3C3C3};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // starts and ends just after a falling edge
    task automatic translate(input logic [31:0] va, input bit exp_hit,
                             input bit fl_req, input bit fl_rsp, input bit stray);
        logic [31:0] pte;
        logic [31:0] exp_pa;
        pte    = pte_of(va[31:12]);
        exp_pa = {pte[19:0], va[11:0]};
        req_valid = 1'b1; req_vaddr = va; flush = fl_req;
        @(negedge clk);
        req_valid = 1'b0; flush = 1'b0;
        if (exp_hit) begin
            chk(done === 1'b1 && mem_req_valid === 1'b0, "R2 hit result", {30'b0, done, mem_req_valid}, 32'h2);
            chk(paddr === exp_pa, "R2 hit paddr", paddr, exp_pa);
            @(negedge clk);
            chk(done === 1'b0, "R10 done pulse", {31'b0, done}, 32'h0);
        end else begin
            chk(mem_req_valid === 1'b1 && done === 1'b0, "R3 miss read", {30'b0, mem_req_valid, done}, 32'h2);
            chk(mem_req_addr === BASE + {va[31:12], 2'b00}, "R3 entry address", mem_req_addr, BASE + {va[31:12], 2'b00});
            @(negedge clk);
            chk(mem_req_valid === 1'b0 && ready === 1'b0, "R3/R9 one-cycle read, busy", {30'b0, mem_req_valid, ready}, 32'h0);
            if (stray) begin
                req_valid = 1'b1; req_vaddr = 32'h0777_7000;
            end
            @(negedge clk);
            req_valid = 1'b0;
            mem_rsp_valid = 1'b1; mem_rsp_data = pte; flush = fl_rsp;
            @(negedge clk);
            mem_rsp_valid = 1'b0; flush = 1'b0;
            if (pte[31]) begin
                chk(done === 1'b1 && fault === 1'b0 && paddr === exp_pa, "R4 walk result", paddr, exp_pa);
            end else begin
                chk(fault === 1'b1 && done === 1'b0, "R5 fault pulse", {30'b0, fault, done}, 32'h2);
            end
            if (stray) begin
                @(negedge clk);
                chk(done === 1'b0 && fault === 1'b0 && mem_req_valid === 1'b0,
                    "R9 request while busy dropped", {29'b0, done, fault, mem_req_valid}, 32'h0);
            end
        end
    endtask

    // {expected hit, virtual address}
    localparam logic [32:0] VEC [17] = '{
        {1'b0, 32'h0000_8123},  // R1 empty buffer
        {1'b1, 32'h0000_8FFF},  // R2 same page, top offset
        {1'b0, 32'h0001_0004},  // R6 second page, set 0
        {1'b1, 32'h0000_8000},  // R6 both held
        {1'b1, 32'h0001_0ABC},
        {1'b0, 32'h0001_8010},  // R7 evicts page 0x8
        {1'b1, 32'h0001_0000},
        {1'b0, 32'h0000_8444},  // R7 page 0x8 was evicted
        {1'b0, 32'h0001_8000},  // R7 page 0x18 was evicted
        {1'b1, 32'h0000_8001},
        {1'b0, 32'h00F0_0123},  // R5 fault
        {1'b0, 32'h00F0_0123},  // R5 not installed
        {1'b0, 32'hFFFF_E7FF},  // R5 fault, high page
        {1'b0, 32'hABCD_E321},  // R4 set 6
        {1'b1, 32'hABCD_E000},  // R4 installed
        {1'b1, 32'h0000_8ABC},  // R5 faults left set 0 intact
        {1'b0, 32'h1234_5678}
    };

    initial begin
        repeat (3) @(negedge clk);
        chk(ready === 1'b1 && done === 1'b0 && fault === 1'b0 && mem_req_valid === 1'b0,
            "R1 reset outputs", {28'b0, ready, done, fault, mem_req_valid}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready === 1'b1 && done === 1'b0, "R1 idle after reset", {30'b0, ready, done}, 32'h2);

        for (int i = 0; i < 17; i++) begin
            translate(VEC[i][31:0], VEC[i][32], 1'b0, 1'b0, 1'b0);
        end

        // R9: request offered during a walk is dropped
        translate(32'h0555_5010, 1'b0, 1'b0, 1'b0, 1'b1);
        translate(32'h0555_5020, 1'b1, 1'b0, 1'b0, 1'b0);

        // R8: standalone flush empties the buffer
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        translate(32'h0000_8000, 1'b0, 1'b0, 1'b0, 1'b0);
        translate(32'h1234_5000, 1'b0, 1'b0, 1'b0, 1'b0);
        translate(32'h1234_5004, 1'b1, 1'b0, 1'b0, 1'b0);

        // R8: flush with request forces a walk
        translate(32'h1234_5008, 1'b0, 1'b1, 1'b0, 1'b0);

        // R8: flush coinciding with refill wins
        translate(32'h0222_2000, 1'b0, 1'b0, 1'b1, 1'b0);
        translate(32'h0222_2000, 1'b0, 1'b0, 1'b0, 1'b0);
        translate(32'h0222_2FF0, 1'b1, 1'b0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule